// File: doc/BRIEF.md
# Display Plane Flip Register Shadowing

This block keeps the programming state of one display plane: the line pitch, the panning displacement and the surface base address. Software writes go into a pending copy of each register, and the active copy feeds scanout. A write to the base-address register is the only thing that arms a flip. On the next vertical-blank pulse, all three pending values are copied into the active set in the same cycle. Software is therefore expected to program the pitch and the displacement first and the base last.

From the active set, the block forms the byte address of the first displayed pixel. It also keeps a running line address for the scanout engine. A frame-start pulse reloads that line address. Each line-advance pulse moves it by one pitch, upward normally and downward when 180-degree rotation is selected. Under rotation, software programs the displacement so that it points at the final pixel of the final unrotated line. A programming-error flag reports an active pitch that is illegal for tiled surfaces.

Top module: `plane_flip_regs`

## Requirements
- R1: After reset, every pending and active register, the line address, the armed flag and the error flag are zero.
- R2: The pitch register stores bits 31:6 of the written word. Bits 5:0 always read and act as zero, so the pitch is a multiple of 64 bytes.
- R3: Writes to the pitch (wr_sel=0) or the displacement (wr_sel=1) leave the active values unchanged. A vertical-blank pulse with no flip armed also leaves the active values unchanged.
- R4: A write to the base register (wr_sel=2) sets `armed` on the next edge. The next vertical-blank pulse copies the pending pitch, displacement and base to the active outputs together and clears `armed`.
- R5: A second base write before the vertical blank keeps the flip armed, and the newest pending values are the ones committed.
- R6: `first_pix` equals the active base plus the active displacement.
- R7: A frame-start pulse loads `line_addr` with `first_pix`, and frame-start takes priority over line-advance. A line-advance pulse adds the active pitch, or subtracts it when `rot180` is 1.
- R8: With `tiled`=1, `prog_err` is 1 when the active pitch is not a multiple of 512 bytes.
- R9: With `tiled`=1, `prog_err` is 1 when the active pitch exceeds 16384 bytes. With `tiled`=0, `prog_err` stays 0 for any pitch.
- R10: `rd_data` returns the pending (last written) value of the register chosen by `rd_sel` (0 pitch, 1 displacement, 2 base, 3 zero), including before the flip commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 pitch, 1 displacement, 2 base |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read target, same encoding |
| rd_data | output | 32 | Pending value of the selected register |
| vblank | input | 1 | Vertical-blank pulse |
| tiled | input | 1 | Surface uses tiled layout |
| rot180 | input | 1 | 180-degree rotation enable |
| frame_start | input | 1 | Reload line address from first pixel |
| line_adv | input | 1 | Step line address by one pitch |
| armed | output | 1 | Flip pending until next vertical blank |
| act_stride | output | 32 | Active pitch in bytes |
| act_offset | output | 32 | Active displacement |
| act_start | output | 32 | Active base address |
| first_pix | output | 32 | Address of first displayed pixel |
| line_addr | output | 32 | Current scanout line address |
| prog_err | output | 1 | Illegal tiled pitch in active set |

## Verification
The bench checks that a pitch or displacement write followed by a blank does not leak into the active set. A design that committed on each write would tear the frame mid-scan. It checks that two base writes in a row commit the newer values. A design that latched on the first write would display a stale surface. It checks the tiled alignment and 16 KB limits at their exact edges, including that a linear surface never flags. It also checks that rotation reverses the line step and that frame-start wins over a simultaneous line-advance, since a wrong sign or priority sends scanout to the wrong lines.

// File: rtl/plane_flip_regs.sv
module plane_flip_regs #(
  parameter int AW        = 32,
  parameter int PITCH_LSB = 6,
  parameter int TILE_LSB  = 9,
  parameter int TILE_MAX  = 16384
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [AW-1:0] rd_data,
  input  logic          vblank,
  input  logic          tiled,
  input  logic          rot180,
  input  logic          frame_start,
  input  logic          line_adv,
  output logic          armed,
  output logic [AW-1:0] act_stride,
  output logic [AW-1:0] act_offset,
  output logic [AW-1:0] act_start,
  output logic [AW-1:0] first_pix,
  output logic [AW-1:0] line_addr,
  output logic          prog_err
);
  localparam logic [1:0] SEL_PITCH = 2'd0;
  localparam logic [1:0] SEL_DISP  = 2'd1;
  localparam logic [1:0] SEL_BASE  = 2'd2;
  localparam logic [AW-1:0] PITCH_MASK = {{(AW-PITCH_LSB){1'b1}}, {PITCH_LSB{1'b0}}};
  localparam logic [AW-1:0] TILE_LIM   = AW'(TILE_MAX);

  logic [AW-1:0] pnd_pitch, pnd_disp, pnd_base;
  logic commit;

  assign commit    = armed & vblank;
  assign first_pix = act_start + act_offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pnd_pitch <= '0;
      pnd_disp  <= '0;
      pnd_base  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_PITCH: pnd_pitch <= wr_data & PITCH_MASK;
        SEL_DISP:  pnd_disp  <= wr_data;
        SEL_BASE:  pnd_base  <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      armed <= 1'b0;
    else if (wr_en && wr_sel == SEL_BASE)
      armed <= 1'b1;
    else if (vblank)
      armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_stride <= '0;
      act_offset <= '0;
      act_start  <= '0;
    end else if (commit) begin
      act_stride <= pnd_pitch;
      act_offset <= pnd_disp;
      act_start  <= pnd_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      line_addr <= '0;
    else if (frame_start)
      line_addr <= first_pix;
    else if (line_adv)
      line_addr <= rot180 ? line_addr - act_stride : line_addr + act_stride;
  end

  always_comb begin
    case (rd_sel)
      SEL_PITCH: rd_data = pnd_pitch;
      SEL_DISP:  rd_data = pnd_disp;
      SEL_BASE:  rd_data = pnd_base;
      default:   rd_data = '0;
    endcase
  end

  assign prog_err = tiled & ((act_stride[TILE_LSB-1:0] != '0) | (act_stride > TILE_LIM));
endmodule

module plane_flip_regs_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic          vblank,
  input logic          rot180,
  input logic          frame_start,
  input logic          line_adv,
  input logic          armed,
  input logic [AW-1:0] act_stride,
  input logic [AW-1:0] act_offset,
  input logic [AW-1:0] act_start,
  input logic [AW-1:0] first_pix,
  input logic [AW-1:0] line_addr
);
  a_r4_arm_on_base: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> armed);

  a_r4_clear_on_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && vblank && !(wr_en && wr_sel == 2'd2)) |=> !armed);

  a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && vblank) |=> ($stable(act_stride) && $stable(act_offset) && $stable(act_start)));

  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> line_addr == $past(first_pix));

  a_r7_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && line_adv && !rot180) |=> line_addr == $past(line_addr) + $past(act_stride));

  a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && line_adv && rot180) |=> line_addr == $past(line_addr) - $past(act_stride));
endmodule

bind plane_flip_regs plane_flip_regs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .vblank(vblank),
  .rot180(rot180), .frame_start(frame_start), .line_adv(line_adv), .armed(armed),
  .act_stride(act_stride), .act_offset(act_offset), .act_start(act_start),
  .first_pix(first_pix), .line_addr(line_addr)
);

// File: tb/tb_plane_flip_regs.sv
module tb_plane_flip_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [31:0] rd_data;
  logic vblank = 1'b0, tiled = 1'b0, rot180 = 1'b0, frame_start = 1'b0, line_adv = 1'b0;
  logic armed, prog_err;
  logic [31:0] act_stride, act_offset, act_start, first_pix, line_addr;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  plane_flip_regs dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .vblank(vblank), .tiled(tiled), .rot180(rot180),
    .frame_start(frame_start), .line_adv(line_adv), .armed(armed),
    .act_stride(act_stride), .act_offset(act_offset), .act_start(act_start),
    .first_pix(first_pix), .line_addr(line_addr), .prog_err(prog_err)
  );

  // {tiled, expected prog_err, written pitch}
  localparam int NV = 7;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h0000_1000},
    {1'b0, 1'b0, 32'h0000_1040},
    {1'b1, 1'b1, 32'h0000_1040},
    {1'b1, 1'b0, 32'h0000_4000},
    {1'b1, 1'b1, 32'h0000_4200},
    {1'b0, 1'b0, 32'h0000_0A3F},
    {1'b0, 1'b0, 32'h0000_8000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_vb();
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rd_sel = s; #1 v = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 act_stride", act_stride, 0);
    chk("R1 act_start", act_start, 0);
    chk("R1 act_offset", act_offset, 0);
    chk("R1 line_addr", line_addr, 0);
    chk("R1 armed", {31'b0, armed}, 0);
    chk("R1 prog_err", {31'b0, prog_err}, 0);
    rd(2'd0, v); chk("R1 rd pitch", v, 0);
    rd(2'd2, v); chk("R1 rd base", v, 0);

    // Vector walk: R2 masking, R8/R9 tiled rules
    for (int i = 0; i < NV; i++) begin
      tiled = VEC[i][33];
      wr(2'd0, VEC[i][31:0]);
      wr(2'd2, 32'h0001_0000);
      pulse_vb();
      rd(2'd0, v);
      chk("R2 rd pitch masked", v, VEC[i][31:0] & 32'hFFFF_FFC0);
      chk("R2 act pitch masked", act_stride, VEC[i][31:0] & 32'hFFFF_FFC0);
      chk("R8 R9 prog_err", {31'b0, prog_err}, {31'b0, VEC[i][32]});
    end
    tiled = 1'b0;

    // R3 and R10: pending only, blank without arm
    wr(2'd0, 32'h0000_2000);
    wr(2'd1, 32'h0000_0100);
    pulse_vb();
    chk("R3 act pitch held", act_stride, 32'h0000_8000);
    chk("R3 act offset held", act_offset, 0);
    chk("R3 armed low", {31'b0, armed}, 0);
    rd(2'd0, v); chk("R10 rd pitch pending", v, 32'h0000_2000);
    rd(2'd1, v); chk("R10 rd disp pending", v, 32'h0000_0100);
    rd(2'd3, v); chk("R10 rd sel3 zero", v, 0);

    // R4 arm then commit
    wr(2'd2, 32'h0002_0000);
    chk("R4 armed set", {31'b0, armed}, 1);
    chk("R4 act start before blank", act_start, 32'h0001_0000);
    rd(2'd2, v); chk("R10 rd base pending", v, 32'h0002_0000);
    pulse_vb();
    chk("R4 armed clear", {31'b0, armed}, 0);
    chk("R4 act start", act_start, 32'h0002_0000);
    chk("R4 act pitch", act_stride, 32'h0000_2000);
    chk("R4 act offset", act_offset, 32'h0000_0100);
    chk("R6 first_pix", first_pix, 32'h0002_0100);

    // R5 re-arm with newest
    wr(2'd2, 32'h0003_0000);
    wr(2'd2, 32'h0004_0000);
    chk("R5 still armed", {31'b0, armed}, 1);
    pulse_vb();
    chk("R5 newest start", act_start, 32'h0004_0000);
    chk("R6 first_pix newest", first_pix, 32'h0004_0100);

    // R7 line stepping
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    chk("R7 reload", line_addr, 32'h0004_0100);
    @(negedge clk); line_adv = 1'b1;
    @(negedge clk);
    @(negedge clk); line_adv = 1'b0;
    chk("R7 step up x2", line_addr, 32'h0004_4100);
    rot180 = 1'b1;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0; line_adv = 1'b1;
    @(negedge clk); line_adv = 1'b0;
    chk("R7 step down rotated", line_addr, 32'h0003_E100);
    @(negedge clk); frame_start = 1'b1; line_adv = 1'b1;
    @(negedge clk); frame_start = 1'b0; line_adv = 1'b0;
    chk("R7 frame_start priority", line_addr, 32'h0004_0100);
    rot180 = 1'b0;

    // R9 linear never flags, tiled exact limit vs just over
    wr(2'd0, 32'h0000_4000); wr(2'd2, 32'h0004_0000); pulse_vb();
    tiled = 1'b1; #1;
    chk("R9 tiled 16K ok", {31'b0, prog_err}, 0);
    tiled = 1'b0;
    wr(2'd0, 32'h0000_4040); wr(2'd2, 32'h0004_0000); pulse_vb();
    #1 chk("R9 linear no flag", {31'b0, prog_err}, 0);
    tiled = 1'b1; #1;
    chk("R8 tiled misaligned flag", {31'b0, prog_err}, 1);
    tiled = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule